// File: doc/BRIEF.md
# Parallel Chase Test-Pattern Evaluator

This block performs the test-pattern step of a soft-input decoder for an extended single-error-correcting BCH(32,26) component code. It takes a 32-symbol soft vector and the positions of three unreliable symbols. Each soft symbol is 5 bits: a sign bit that gives the hard decision, and a 4-bit magnitude. From these inputs the block forms all eight Chase test patterns and evaluates them side by side in one combinational pass. It then registers the best candidate codeword.

For each pattern, the block updates the base syndrome by the syndrome columns of the inverted symbols. A nonzero result corrects one bit. The overall parity symbol is then repaired, and a metric is built by adding up the magnitudes of every symbol the candidate changes. A minimum-selection tree picks the winner. The decided word, its metric, its pattern index and its correction position appear one cycle after a strobed input. A caller feeds one vector per cycle and reads the result on the next.

The block has no control state beyond its output register. Each cycle with `in_valid` high loads a new result. Each cycle with `in_valid` low keeps the previous result.

Top module: `tpe_chase_eval`

## Requirements
- R1: Symbol i of the soft input occupies bits [5i+4:5i]. Bit 5i+4 is the hard decision (1 means a hard one) and bits [5i+3:5i] are the magnitude. The syndrome column of position i is the 5-bit value i+1 for i from 0 to 30. Position 31 is the overall parity symbol and has column zero.
- R2: `lrb_pos` holds three distinct positions, with unreliable position j at bits [5j+4:5j]. Pattern k inverts unreliable position j exactly when bit j of k is set, for k from 0 to 7.
- R3: The syndrome of a pattern is the syndrome of the base hard word XORed with the columns of its inverted positions. A nonzero syndrome s inverts position s-1 and sets the correction flag with correction position s-1. A zero syndrome clears the flag and reports position 0.
- R4: After the correction, if the candidate word has odd weight, position 31 is inverted so that the weight is even.
- R5: The metric of a pattern is the sum of the magnitudes of all positions where its candidate word differs from the hard decisions. An unreliable bit that is inverted and then corrected back therefore adds nothing.
- R6: The decided pattern has the smallest metric. When metrics tie, the lowest pattern index wins.
- R7: The outputs change only on a rising clock edge with `in_valid` high, and they are valid from the next edge. `out_valid` is high for exactly the cycle after each strobed input. With `in_valid` low, the result outputs hold their values.
- R8: While `rst_n` is low, every output is zero.
- R9: Every decided word has a zero syndrome and even weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that loads a new result |
| soft_in | input | 160 | 32 soft symbols, 5 bits each (sign and magnitude) |
| lrb_pos | input | 15 | Three unreliable positions, 5 bits each |
| out_valid | output | 1 | High in the cycle after a strobe |
| dec_word | output | 32 | Decided codeword |
| dec_metric | output | 7 | Metric of the decided word |
| dec_pattern | output | 3 | Index of the winning pattern |
| corr_valid | output | 1 | Winning pattern needed a syndrome correction |
| corr_pos | output | 5 | Position corrected by the syndrome |

## Verification
The directed vectors are chosen so that each one separates a different path through the evaluator:
- An all-zero word and a codeword with set bits confirm that a clean input wins with pattern 0 and metric zero.
- A single error outside the unreliable set exercises the syndrome-driven correction.
- An error sitting on an unreliable bit forces a metric tie between patterns 0 and 2, which tests the index tie-break.
- A parity-only error on an unreliable parity symbol tests the parity repair together with the zero syndrome column.
- A two-error word can only be fixed by a nonzero pattern.

Random soft vectors with random distinct unreliable positions are then compared against a model that recomputes the syndrome from scratch for each candidate, rather than incrementally.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
    localparam int N_BITS = 32;
    localparam int SYN_W  = 5;
    localparam int MAG_W  = 4;
    localparam int SOFT_W = MAG_W + 1;
    localparam int N_LRB  = 3;
    localparam int N_PAT  = 1 << N_LRB;
    localparam int PAT_W  = N_LRB;
    localparam int MET_W  = MAG_W + 3;

    typedef struct packed {
        logic [MET_W-1:0]  metric;
        logic [N_BITS-1:0] word;
        logic              corr_valid;
        logic [SYN_W-1:0]  corr_pos;
    } pat_res_t;
endpackage

// File: rtl/tpe_base_syndrome.sv
module tpe_base_syndrome
    import tpe_pkg::*;
(
    input  logic [N_BITS-1:0] hard,
    output logic [SYN_W-1:0]  syn,
    output logic              par
);
    // Each syndrome bit XORs the hard bits whose column has that bit set;
    // common sub-terms are left for synthesis to share between bits.
    for (genvar k = 0; k < SYN_W; k++) begin : g_syn
        logic [N_BITS-1:0] taps;
        for (genvar i = 0; i < N_BITS; i++) begin : g_tap
            localparam logic [SYN_W-1:0] COL = SYN_W'(i + 1);
            assign taps[i] = hard[i] & COL[k];
        end
        assign syn[k] = ^taps;
    end

    assign par = ^hard;
endmodule

// File: rtl/tpe_pattern_eval.sv
module tpe_pattern_eval
    import tpe_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [N_BITS-1:0]       hard,
    input  logic [N_BITS*MAG_W-1:0] mags,
    input  logic [SYN_W-1:0]        syn0,
    input  logic                    par0,
    input  logic [N_LRB*SYN_W-1:0]  lrb_pos,
    output pat_res_t                res
);
    localparam logic [N_LRB-1:0] SEL = N_LRB'(IDX);

    always_comb begin
        logic [SYN_W-1:0]  s;
        logic [SYN_W-1:0]  p;
        logic [N_BITS-1:0] flip;
        logic [MET_W-1:0]  acc;
        s    = syn0;
        p    = '0;
        flip = '0;
        // incremental syndrome from the inverted unreliable bits
        for (int j = 0; j < N_LRB; j++) begin
            if (SEL[j]) begin
                p       = lrb_pos[j*SYN_W +: SYN_W];
                flip[p] = ~flip[p];
                s       = s ^ (p + SYN_W'(1));
            end
        end
        res.corr_valid = (s != '0);
        res.corr_pos   = res.corr_valid ? (s - SYN_W'(1)) : '0;
        if (res.corr_valid) begin
            flip[res.corr_pos] = ~flip[res.corr_pos];
        end
        // parity repair on the overall parity symbol
        if (par0 ^ (^flip)) begin
            flip[N_BITS-1] = ~flip[N_BITS-1];
        end
        // additive metric: magnitude of every changed position
        acc = '0;
        for (int i = 0; i < N_BITS; i++) begin
            if (flip[i]) begin
                acc = acc + MET_W'(mags[i*MAG_W +: MAG_W]);
            end
        end
        res.metric = acc;
        res.word   = hard ^ flip;
    end
endmodule

// File: rtl/tpe_min_select.sv
module tpe_min_select
    import tpe_pkg::*;
(
    input  pat_res_t         cand [N_PAT],
    output pat_res_t         best,
    output logic [PAT_W-1:0] best_idx
);
    localparam int NODES = 2 * N_PAT - 1;
    localparam int LEAF0 = N_PAT - 1;

    // Heap-ordered tree; the left child always covers lower indices, so
    // taking it on a tie keeps the lowest pattern index.
    always_comb begin
        pat_res_t         r  [NODES];
        logic [PAT_W-1:0] ix [NODES];
        for (int n = 0; n < N_PAT; n++) begin
            r[LEAF0+n]  = cand[n];
            ix[LEAF0+n] = PAT_W'(n);
        end
        for (int n = LEAF0 - 1; n >= 0; n--) begin
            if (r[2*n+2].metric < r[2*n+1].metric) begin
                r[n]  = r[2*n+2];
                ix[n] = ix[2*n+2];
            end else begin
                r[n]  = r[2*n+1];
                ix[n] = ix[2*n+1];
            end
        end
        best     = r[0];
        best_idx = ix[0];
    end
endmodule

// File: rtl/tpe_chase_eval.sv
module tpe_chase_eval
    import tpe_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [N_BITS*SOFT_W-1:0]   soft_in,
    input  logic [N_LRB*SYN_W-1:0]     lrb_pos,
    output logic                       out_valid,
    output logic [N_BITS-1:0]          dec_word,
    output logic [MET_W-1:0]           dec_metric,
    output logic [PAT_W-1:0]           dec_pattern,
    output logic                       corr_valid,
    output logic [SYN_W-1:0]           corr_pos
);
    logic [N_BITS-1:0]       hard;
    logic [N_BITS*MAG_W-1:0] mags;
    logic [SYN_W-1:0]        syn0;
    logic                    par0;
    pat_res_t                cand [N_PAT];
    pat_res_t                best;
    logic [PAT_W-1:0]        best_idx;

    for (genvar i = 0; i < N_BITS; i++) begin : g_split
        assign hard[i]                 = soft_in[i*SOFT_W + MAG_W];
        assign mags[i*MAG_W +: MAG_W]  = soft_in[i*SOFT_W +: MAG_W];
    end

    tpe_base_syndrome u_base (
        .hard (hard),
        .syn  (syn0),
        .par  (par0)
    );

    for (genvar k = 0; k < N_PAT; k++) begin : g_pat
        tpe_pattern_eval #(.IDX(k)) u_pat (
            .hard    (hard),
            .mags    (mags),
            .syn0    (syn0),
            .par0    (par0),
            .lrb_pos (lrb_pos),
            .res     (cand[k])
        );
    end

    tpe_min_select u_sel (
        .cand     (cand),
        .best     (best),
        .best_idx (best_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            dec_word    <= '0;
            dec_metric  <= '0;
            dec_pattern <= '0;
            corr_valid  <= 1'b0;
            corr_pos    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dec_word    <= best.word;
                dec_metric  <= best.metric;
                dec_pattern <= best_idx;
                corr_valid  <= best.corr_valid;
                corr_pos    <= best.corr_pos;
            end
        end
    end
endmodule

// File: rtl/tpe_chase_eval_chk.sv
module tpe_chase_eval_chk
    import tpe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [N_BITS-1:0] dec_word,
    input logic [MET_W-1:0]  dec_metric,
    input logic [PAT_W-1:0]  dec_pattern
);
    localparam int MAX_MET = (N_LRB + 2) * ((1 << MAG_W) - 1);

    logic [SYN_W-1:0] word_syn;
    always_comb begin
        word_syn = '0;
        for (int i = 0; i < N_BITS; i++) begin
            if (dec_word[i]) word_syn = word_syn ^ SYN_W'(i + 1);
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dec_word) && $stable(dec_metric) && $stable(dec_pattern)));
    // R9
    codeword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (word_syn == '0 && !(^dec_word)));
    // R5
    metric_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(dec_metric) <= MAX_MET));
endmodule

bind tpe_chase_eval tpe_chase_eval_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .dec_word    (dec_word),
    .dec_metric  (dec_metric),
    .dec_pattern (dec_pattern)
);

// File: tb/tpe_chase_eval_bench.sv
`timescale 1ns/1ps
module tpe_chase_eval_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [159:0] soft_in = '0;
    logic [14:0]  lrb_pos = '0;
    logic         out_valid;
    logic [31:0]  dec_word;
    logic [6:0]   dec_metric;
    logic [2:0]   dec_pattern;
    logic         corr_valid;
    logic [4:0]   corr_pos;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    tpe_chase_eval u_tpe_chase_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .soft_in(soft_in),
        .lrb_pos(lrb_pos), .out_valid(out_valid), .dec_word(dec_word),
        .dec_metric(dec_metric), .dec_pattern(dec_pattern),
        .corr_valid(corr_valid), .corr_pos(corr_pos)
    );

    typedef struct packed {
        logic [6:0]  metric;
        logic [2:0]  pat;
        logic        cv;
        logic [4:0]  cp;
        logic [31:0] word;
    } exp_t;

    typedef struct packed {
        logic [31:0] hard;
        logic [14:0] lrb;
        exp_t        exp;
    } vec_t;

    // hard mask, unreliable positions {l2,l1,l0}, expected result
    localparam vec_t VECS [6] = '{
        // clean zero word, pattern 0 wins (R6)
        '{32'h0000_0000, {5'd2, 5'd1, 5'd0},  '{7'd0, 3'd0, 1'b0, 5'd0, 32'h0}},
        // single error at 4, syndrome correction (R3)
        '{32'h0000_0010, {5'd2, 5'd1, 5'd0},  '{7'd8, 3'd0, 1'b1, 5'd4, 32'h0}},
        // error on unreliable bit 1: tie of patterns 0 and 2 (R6)
        '{32'h0000_0002, {5'd2, 5'd1, 5'd0},  '{7'd2, 3'd0, 1'b1, 5'd1, 32'h0}},
        // parity-only error on unreliable parity symbol (R4, R1)
        '{32'h8000_0000, {5'd1, 5'd0, 5'd31}, '{7'd1, 3'd0, 1'b0, 5'd0, 32'h0}},
        // two errors, pattern 1 wins with metric 1+8 (R2, R5)
        '{32'h0000_0201, {5'd2, 5'd1, 5'd0},  '{7'd9, 3'd1, 1'b1, 5'd9, 32'h0}},
        // nonzero codeword passes unchanged (R9)
        '{32'h8000_0007, {5'd12, 5'd11, 5'd10}, '{7'd0, 3'd0, 1'b0, 5'd0, 32'h8000_0007}}
    };

    function automatic logic [159:0] mk_soft(input logic [31:0] hard, input logic [14:0] lrb);
        logic [159:0] s;
        for (int i = 0; i < 32; i++) s[i*5 +: 5] = {hard[i], 4'd8};
        for (int j = 0; j < 3; j++) s[lrb[j*5 +: 5]*5 +: 4] = 4'(j + 1);
        return s;
    endfunction

    // independent model: full syndrome recomputation per candidate
    function automatic exp_t model(input logic [159:0] s, input logic [14:0] lrb);
        exp_t        b;
        logic [31:0] hd;
        b = '0;
        for (int i = 0; i < 32; i++) hd[i] = s[i*5 + 4];
        for (int p = 0; p < 8; p++) begin
            logic [31:0] w;
            logic [4:0]  syn;
            int          m;
            w = hd;
            for (int j = 0; j < 3; j++) if (p[j]) w[lrb[j*5 +: 5]] = ~w[lrb[j*5 +: 5]];
            syn = '0;
            for (int i = 0; i < 31; i++) if (w[i]) syn = syn ^ 5'(i + 1);
            if (syn != 0) w[syn - 5'd1] = ~w[syn - 5'd1];
            if (^w) w[31] = ~w[31];
            m = 0;
            for (int i = 0; i < 32; i++) if (w[i] != hd[i]) m += int'(s[i*5 +: 4]);
            if (p == 0 || m < int'(b.metric)) begin
                b.metric = 7'(m);
                b.pat    = 3'(p);
                b.cv     = (syn != 0);
                b.cp     = (syn != 0) ? syn - 5'd1 : 5'd0;
                b.word   = w;
            end
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic run_vec(input logic [159:0] s, input logic [14:0] l,
                           input exp_t e, input string req);
        exp_t got;
        @(negedge clk);
        soft_in  = s;
        lrb_pos  = l;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got = '{dec_metric, dec_pattern, corr_valid, corr_pos, dec_word};
        check(out_valid == 1'b1, "R7", "out_valid", longint'(out_valid), 1);
        check(got == e, req, "result", longint'(got), longint'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check({out_valid, dec_word, dec_metric, dec_pattern, corr_valid, corr_pos} == '0,
              "R8", "reset outputs", longint'(dec_word), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            run_vec(mk_soft(VECS[v].hard, VECS[v].lrb), VECS[v].lrb, VECS[v].exp, "R1 R2 R3 R4 R5 R6");
        end

        // R7: hold with in_valid low while inputs change
        begin
            logic [31:0] w0;
            logic [6:0]  m0;
            w0 = dec_word;
            m0 = dec_metric;
            soft_in = mk_soft(32'h0000_0010, {5'd2, 5'd1, 5'd0});
            repeat (2) @(negedge clk);
            check(out_valid == 1'b0, "R7", "out_valid low", longint'(out_valid), 0);
            check(dec_word == w0 && dec_metric == m0, "R7", "hold metric",
                  longint'(dec_metric), longint'(m0));
        end

        // random vectors against the model
        for (int r = 0; r < 300; r++) begin
            logic [159:0] s;
            logic [14:0]  l;
            logic [4:0]   a, b, c;
            for (int i = 0; i < 5; i++) s[i*32 +: 32] = $urandom;
            a = 5'($urandom);
            b = 5'($urandom);
            while (b == a) b = 5'($urandom);
            c = 5'($urandom);
            while (c == a || c == b) c = 5'($urandom);
            l = {c, b, a};
            run_vec(s, l, model(s, l), "R3 R4 R5 R6");
        end

        // R8: reset again mid-run clears results
        rst_n = 1'b0;
        @(negedge clk);
        check({out_valid, dec_word, dec_metric} == '0, "R8", "reset clear",
              longint'(dec_metric), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule